// File: doc/BRIEF.md
# Reciprocal Period Counter with Power-of-Two Prescaler

The block measures the period of one of several asynchronous input signals by counting reference clock cycles. The input to be measured is picked by a select code. Its rising edges are divided by a programmable power of two, 2^n. The reference counter then runs across a host-chosen number of those divided cycles. The gate length is therefore set by the input itself and not by a fixed time window. The count is proportional to the input period, and a higher n or a larger cycle count gives finer resolution.

The host configures the block through a narrow bus. Writes to the listen address shift one data bit at a time into a six-bit configuration register that holds the select code and n. A start strobe latches this configuration and the cycle target, and arms the measurement. When the measurement finishes, a done flag rises. The host then reads the result one byte at a time at the talk address. Reading the last byte clears done. If the count would pass its all-ones value, it stays there and an overflow flag is set.

Top module: `period_meter`

## Requirements
- R1: After reset, busy, done and overflow are low and every result byte reads as zero.
- R2: Each clock with bus_wr high and bus_addr equal to the listen address (0x73) shifts bus_wbit into bit 0 of a six-bit configuration register, moving the older bits up by one position. The six most recently shifted bits are interpreted in arrival order as sel[1], sel[0], n[3], n[2], n[1], n[0]. Bits shifted in before those six have no effect.
- R3: A write at any other address, and a listen-address cycle with bus_wr low, leaves the configuration unchanged.
- R4: The select code, n and gate_cycles are taken only at a start strobe. A configuration shifted in during a measurement has no effect until the next start.
- R5: The result equals the number of reference cycles from the first divided edge after start to the gate_cycles-th divided edge after it. For a periodic input with a period of P reference cycles, this is P * 2^n * gate_cycles.
- R6: A gate_cycles value of zero behaves as one.
- R7: A divided edge occurs on every 2^n-th synchronized rising edge of the selected input, counted from the start strobe.
- R8: If the count would pass all ones, it holds at all ones and overflow rises. Overflow stays high until the next start.
- R9: Start raises busy and clears done and overflow. The end of the measurement drops busy and raises done in the same cycle. Busy and done are never high together.
- R10: While bus_addr equals the talk address (0x5F), bus_rdata carries result byte byte_idx, which is result bits 8*byte_idx+7 down to 8*byte_idx. At any other address, bus_rdata is zero.
- R11: A bus_rd strobe at the talk address with byte_idx = 2 (the last byte) clears done. Reads of bytes 0 and 1 leave done set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Bus address, decoded for listen and talk |
| bus_wr | input | 1 | Write strobe |
| bus_wbit | input | 1 | Serial configuration bit (data bit 0) |
| bus_rd | input | 1 | Read strobe, used to clear done on the last byte |
| byte_idx | input | 2 | Result byte selector |
| bus_rdata | output | 8 | Result byte when talk is addressed, else zero |
| sig_in | input | 4 | Asynchronous inputs to be measured |
| start | input | 1 | Latches the configuration and arms a measurement |
| gate_cycles | input | 8 | Number of divided cycles in the gate |
| busy | output | 1 | Measurement armed or running |
| done | output | 1 | Result ready |
| overflow | output | 1 | Count saturated during the last measurement |

## Verification
A wrong prescaler count or a wrong edge detector shows up as a result that is a wrong multiple of the input period. This appears only when done rises, so the time to detect it is a full gate time. A shift register that takes the wrong bits, or bits in the wrong order, measures the wrong input or the wrong ratio, and the result is off by a factor of period or of two. A done or overflow flag that is cleared or set at the wrong time is visible at the ports within one cycle of the start strobe, the end of the gate, or the last-byte read.

// File: rtl/pm_pkg.sv
package pm_pkg;
  localparam int SEL_W = 2;
  localparam int EXP_W = 4;
  localparam int PRE_W = 1 << EXP_W;
  localparam int CFG_W = SEL_W + EXP_W;

  typedef enum logic [1:0] {
    GS_IDLE = 2'd0,
    GS_ARM  = 2'd1,
    GS_RUN  = 2'd2
  } gate_state_e;

  // first bits shifted in land in sel
  typedef struct packed {
    logic [SEL_W-1:0] sel;
    logic [EXP_W-1:0] expo;
  } cfg_t;

  // last value of the prescaler before it wraps: 2^e - 1
  function automatic logic [PRE_W-1:0] prescale_wrap(input logic [EXP_W-1:0] e);
    prescale_wrap = (PRE_W'(1) << e) - PRE_W'(1);
  endfunction
endpackage

// File: rtl/pm_bus_if.sv
module pm_bus_if #(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] LISTEN_ADDR = ADDR_W'('h73),
  parameter logic [ADDR_W-1:0] TALK_ADDR = ADDR_W'('h5F),
  parameter int CNT_W = 21,
  parameter int IDX_W = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [ADDR_W-1:0]        bus_addr,
  input  logic                     bus_wr,
  input  logic                     bus_wbit,
  input  logic                     bus_rd,
  input  logic [IDX_W-1:0]         byte_idx,
  input  logic [CNT_W-1:0]         result,
  output logic [pm_pkg::CFG_W-1:0] cfg_sr,
  output logic                     listen_wr,
  output logic                     rd_last,
  output logic [7:0]               bus_rdata
);
  localparam int CFG_W  = pm_pkg::CFG_W;
  localparam int NBYTES = (CNT_W + 7) / 8;
  localparam int PAD_W  = NBYTES * 8;
  localparam int SLOTS  = 1 << IDX_W;

  logic listen_hit;
  logic talk_hit;
  assign listen_hit = (bus_addr == LISTEN_ADDR);
  assign talk_hit   = (bus_addr == TALK_ADDR);
  assign listen_wr  = listen_hit && bus_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_sr <= '0;
    else if (listen_wr) cfg_sr <= {cfg_sr[CFG_W-2:0], bus_wbit};
  end

  logic [PAD_W-1:0] res_pad;
  logic [7:0]       slot [SLOTS];
  assign res_pad = PAD_W'(result);

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    if (g < NBYTES) begin : g_live
      assign slot[g] = res_pad[8*g +: 8];
    end else begin : g_pad
      assign slot[g] = 8'h00;
    end
  end

  assign bus_rdata = talk_hit ? slot[byte_idx] : 8'h00;
  assign rd_last   = talk_hit && bus_rd && (byte_idx == IDX_W'(NBYTES - 1));
endmodule

// File: rtl/pm_prescaler.sv
module pm_prescaler #(
  parameter int NUM_IN = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NUM_IN-1:0]        sig_in,
  input  logic [pm_pkg::SEL_W-1:0] sel,
  input  logic [pm_pkg::EXP_W-1:0] expo,
  input  logic                     restart,
  output logic                     sel_rise,
  output logic                     div_tick
);
  localparam int PRE_W = pm_pkg::PRE_W;

  logic [NUM_IN-1:0] rise_vec;

  // two synchronizer stages and one history stage per input, so that
  // changing the selection never creates a false edge
  for (genvar g = 0; g < NUM_IN; g++) begin : g_in
    logic [2:0] pipe;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe <= '0;
      else pipe <= {pipe[1:0], sig_in[g]};
    end
    assign rise_vec[g] = pipe[1] & ~pipe[2];
  end

  assign sel_rise = rise_vec[sel];

  logic [PRE_W-1:0] pre_cnt;
  logic             at_wrap;
  assign at_wrap  = (pre_cnt == pm_pkg::prescale_wrap(expo));
  assign div_tick = sel_rise && at_wrap && !restart;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_cnt <= '0;
    else if (restart) pre_cnt <= '0;
    else if (sel_rise) pre_cnt <= at_wrap ? '0 : pre_cnt + PRE_W'(1);
  end
endmodule

// File: rtl/pm_gate.sv
module pm_gate #(
  parameter int CNT_W = 21,
  parameter int CYC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CYC_W-1:0] gate_cycles,
  input  logic             div_tick,
  input  logic             clear_done,
  output logic             busy,
  output logic             done,
  output logic             overflow,
  output logic [CNT_W-1:0] result,
  output logic             meas_stop,
  output logic             sat_hit
);
  import pm_pkg::*;

  function automatic logic [CYC_W-1:0] eff_target(input logic [CYC_W-1:0] c);
    eff_target = (c == '0) ? CYC_W'(1) : c;
  endfunction

  gate_state_e      st;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] cnt_nxt;
  logic [CYC_W-1:0] tgt;
  logic [CYC_W-1:0] ticks;

  assign sat_hit   = (st == GS_RUN) && (&cnt);
  assign cnt_nxt   = sat_hit ? cnt : cnt + CNT_W'(1);
  assign meas_stop = (st == GS_RUN) && div_tick && (ticks == tgt - CYC_W'(1));
  assign busy      = (st != GS_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= GS_IDLE;
      cnt      <= '0;
      tgt      <= CYC_W'(1);
      ticks    <= '0;
      done     <= 1'b0;
      overflow <= 1'b0;
      result   <= '0;
    end else if (start) begin
      st       <= GS_ARM;
      tgt      <= eff_target(gate_cycles);
      ticks    <= '0;
      cnt      <= '0;
      done     <= 1'b0;
      overflow <= 1'b0;
    end else begin
      if (clear_done) done <= 1'b0;
      unique case (st)
        GS_ARM: begin
          if (div_tick) begin
            st    <= GS_RUN;
            cnt   <= '0;
            ticks <= '0;
          end
        end
        GS_RUN: begin
          cnt <= cnt_nxt;
          if (sat_hit) overflow <= 1'b1;
          if (meas_stop) begin
            st     <= GS_IDLE;
            done   <= 1'b1;
            result <= cnt_nxt;
          end else if (div_tick) begin
            ticks <= ticks + CYC_W'(1);
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/period_meter.sv
module period_meter #(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] LISTEN_ADDR = ADDR_W'('h73),
  parameter logic [ADDR_W-1:0] TALK_ADDR = ADDR_W'('h5F),
  parameter int CNT_W = 21,
  parameter int CYC_W = 8,
  parameter int IDX_W = 2,
  localparam int NUM_IN = 1 << pm_pkg::SEL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_wbit,
  input  logic              bus_rd,
  input  logic [IDX_W-1:0]  byte_idx,
  output logic [7:0]        bus_rdata,
  input  logic [NUM_IN-1:0] sig_in,
  input  logic              start,
  input  logic [CYC_W-1:0]  gate_cycles,
  output logic              busy,
  output logic              done,
  output logic              overflow
);
  import pm_pkg::*;

  logic [CFG_W-1:0] cfg_sr;
  cfg_t             cfg_act;
  logic             listen_wr;
  logic             rd_last;
  logic             sel_rise;
  logic             div_tick;
  logic             meas_stop;
  logic             sat_hit;
  logic [CNT_W-1:0] res_q;

  // configuration becomes active only at start
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_act <= '0;
    else if (start) cfg_act <= cfg_t'(cfg_sr);
  end

  pm_bus_if #(
    .ADDR_W(ADDR_W), .LISTEN_ADDR(LISTEN_ADDR), .TALK_ADDR(TALK_ADDR),
    .CNT_W(CNT_W), .IDX_W(IDX_W)
  ) u_bus (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wbit(bus_wbit), .bus_rd(bus_rd), .byte_idx(byte_idx),
    .result(res_q), .cfg_sr(cfg_sr), .listen_wr(listen_wr),
    .rd_last(rd_last), .bus_rdata(bus_rdata)
  );

  pm_prescaler #(.NUM_IN(NUM_IN)) u_pre (
    .clk(clk), .rst_n(rst_n), .sig_in(sig_in), .sel(cfg_act.sel),
    .expo(cfg_act.expo), .restart(start), .sel_rise(sel_rise),
    .div_tick(div_tick)
  );

  pm_gate #(.CNT_W(CNT_W), .CYC_W(CYC_W)) u_gate (
    .clk(clk), .rst_n(rst_n), .start(start), .gate_cycles(gate_cycles),
    .div_tick(div_tick), .clear_done(rd_last), .busy(busy), .done(done),
    .overflow(overflow), .result(res_q), .meas_stop(meas_stop),
    .sat_hit(sat_hit)
  );
endmodule

// File: rtl/pm_checker.sv
module pm_checker #(
  parameter int CNT_W = 21
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             busy,
  input logic             done,
  input logic             overflow,
  input logic [CNT_W-1:0] result,
  input logic             listen_wr,
  input logic             bus_wbit,
  input logic             cfg_lsb,
  input logic             rd_last,
  input logic             div_tick,
  input logic             sel_rise,
  input logic             sat_hit,
  input logic             meas_stop
);
  // R2
  cfg_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    listen_wr |=> cfg_lsb == $past(bus_wbit));

  // R7
  tick_on_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    div_tick |-> sel_rise);

  // R8
  sat_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sat_hit && !start |=> overflow);

  // R8
  sat_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overflow && done |-> &result);

  // R9
  start_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy && !done && !overflow);

  // R9
  stop_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    meas_stop && !start |=> done && !busy);

  // R9
  busy_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  // R9
  excl_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done));

  // R11
  last_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_last && !busy |=> !done);
endmodule

bind period_meter pm_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .overflow(overflow), .result(res_q), .listen_wr(listen_wr),
  .bus_wbit(bus_wbit), .cfg_lsb(cfg_sr[0]), .rd_last(rd_last),
  .div_tick(div_tick), .sel_rise(sel_rise), .sat_hit(sat_hit),
  .meas_stop(meas_stop)
);

// File: tb/sim_period_meter.sv
module sim_period_meter;
  localparam int SMALL_W = 8;
  localparam logic [7:0] LISTEN = 8'h73;
  localparam logic [7:0] TALK   = 8'h5F;
  localparam int HALF [4] = '{2, 3, 5, 7};

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic       rst_n;
  logic [7:0] bus_addr;
  logic       bus_wr, bus_wbit, bus_rd;
  logic [1:0] byte_idx;
  logic [3:0] sig_in;
  logic       start;
  logic [7:0] gate_cycles;
  logic [7:0] rdata0, rdata1;
  logic       busy0, done0, ovf0, busy1, done1, ovf1;
  logic       src [4];

  assign sig_in = {src[3], src[2], src[1], src[0]};

  period_meter u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wbit(bus_wbit), .bus_rd(bus_rd), .byte_idx(byte_idx),
    .bus_rdata(rdata0), .sig_in(sig_in), .start(start),
    .gate_cycles(gate_cycles), .busy(busy0), .done(done0), .overflow(ovf0)
  );

  period_meter #(.CNT_W(SMALL_W)) u1 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wbit(bus_wbit), .bus_rd(bus_rd), .byte_idx(byte_idx),
    .bus_rdata(rdata1), .sig_in(sig_in), .start(start),
    .gate_cycles(gate_cycles), .busy(busy1), .done(done1), .overflow(ovf1)
  );

  // input i has a period of 2*HALF[i] reference cycles
  for (genvar i = 0; i < 4; i++) begin : g_src
    initial begin
      src[i] = 1'b0;
      forever begin
        repeat (HALF[i]) @(negedge clk);
        src[i] = ~src[i];
      end
    end
  end

  int     n_cmp = 0;
  int     n_bad = 0;
  int     mon_done = 0;
  longint exp_q [$];

  task automatic chk(input string req, input longint act, input longint exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic longint expect_count(input int sel, input int n, input int cyc);
    int g;
    g = (cyc == 0) ? 1 : cyc;
    return longint'(2 * HALF[sel]) * (longint'(1) << n) * longint'(g);
  endfunction

  task automatic put_bit(input logic [7:0] a, input logic w, input logic b);
    @(negedge clk);
    bus_addr = a; bus_wr = w; bus_wbit = b;
    @(negedge clk);
    bus_wr = 1'b0; bus_addr = 8'h00;
  endtask

  task automatic send_cfg(input int sel, input int n);
    logic [5:0] bits;
    bits = {sel[1:0], n[3:0]};
    for (int i = 5; i >= 0; i--) put_bit(LISTEN, 1'b1, bits[i]);
  endtask

  task automatic kick(input int cyc);
    @(negedge clk);
    start = 1'b1; gate_cycles = cyc[7:0];
    @(negedge clk);
    start = 1'b0;
    chk("R9 busy after start", longint'(busy0), 1);
    chk("R9 done cleared by start", longint'(done0), 0);
  endtask

  task automatic measure(input int sel, input int n, input int cyc);
    int t;
    t = mon_done + 1;
    send_cfg(sel, n);
    exp_q.push_back(expect_count(sel, n, cyc));
    kick(cyc);
    wait (mon_done == t);
    @(negedge clk);
  endtask

  // monitor: reads each finished result and compares with the scoreboard
  initial begin : monitor
    longint got;
    longint want;
    @(posedge rst_n);
    forever begin
      @(negedge clk);
      if (done0 === 1'b1) begin
        got = 0;
        for (int k = 0; k < 3; k++) begin
          bus_addr = TALK; byte_idx = k[1:0]; bus_rd = 1'b1;
          #1;
          got = got | (longint'(rdata0) << (8 * k));
          if (k == 2) chk("R11 done kept after bytes 0 and 1", longint'(done0), 1);
          @(negedge clk);
        end
        bus_rd = 1'b0; bus_addr = 8'h00;
        chk("R11 done cleared by last byte", longint'(done0), 0);
        if (exp_q.size() == 0) begin
          chk("R5 unexpected result", got, -1);
        end else begin
          want = exp_q.pop_front();
          chk("R5 measured count", got, want);
        end
        chk("R8 no overflow on wide counter", longint'(ovf0), 0);
        mon_done++;
      end
    end
  end

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL R5 watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin : driver
    int t;
    logic [5:0] junk;
    rst_n = 1'b0; bus_addr = 8'h00; bus_wr = 1'b0; bus_wbit = 1'b0;
    bus_rd = 1'b0; byte_idx = 2'd0; start = 1'b0; gate_cycles = 8'd0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 busy", longint'(busy0), 0);
    chk("R1 done", longint'(done0), 0);
    chk("R1 overflow", longint'(ovf0), 0);
    for (int k = 0; k < 3; k++) begin
      bus_addr = TALK; byte_idx = k[1:0];
      #1 chk("R1 result byte", longint'(rdata0), 0);
    end
    bus_addr = 8'h00;

    // R5 R7: n = 0, every edge counts
    measure(0, 0, 5);
    // R8: narrow counter below its limit
    bus_addr = TALK; byte_idx = 2'd0;
    #1 chk("R8 narrow counter value", longint'(rdata1), 20);
    chk("R8 narrow counter no overflow", longint'(ovf1), 0);
    bus_addr = 8'h00;

    // R2: two leading bits are pushed out by the next six
    put_bit(LISTEN, 1'b1, 1'b1);
    put_bit(LISTEN, 1'b1, 1'b1);
    measure(1, 2, 3);

    // R7: prescale by 16
    measure(2, 4, 10);

    // R6: zero cycle target acts as one
    measure(3, 1, 0);

    // R3: foreign address and missing strobe are ignored
    send_cfg(0, 0);
    junk = 6'b01_0001;
    for (int i = 5; i >= 0; i--) put_bit(8'h72, 1'b1, junk[i]);
    for (int i = 5; i >= 0; i--) put_bit(LISTEN, 1'b0, junk[i]);
    t = mon_done + 1;
    exp_q.push_back(expect_count(0, 0, 5));
    kick(5);
    wait (mon_done == t);
    @(negedge clk);

    // R4: configuration shifted during a run waits for the next start
    send_cfg(2, 3);
    t = mon_done + 1;
    exp_q.push_back(expect_count(2, 3, 4));
    kick(4);
    send_cfg(0, 1);
    wait (mon_done == t);
    @(negedge clk);
    t = mon_done + 1;
    exp_q.push_back(expect_count(0, 1, 5));
    kick(5);
    wait (mon_done == t);
    @(negedge clk);

    // R10: talk address shows the held result, other addresses read zero
    bus_addr = TALK; byte_idx = 2'd0;
    #1 chk("R10 byte 0 at talk address", longint'(rdata0), 40);
    bus_addr = 8'h00;
    #1 chk("R10 zero when not addressed", longint'(rdata0), 0);
    bus_addr = LISTEN;
    #1 chk("R10 zero at listen address", longint'(rdata0), 0);
    bus_addr = 8'h00;

    // R8: 400 cycles exceed the 8-bit counter
    measure(0, 0, 100);
    chk("R8 overflow flag", longint'(ovf1), 1);
    bus_addr = TALK; byte_idx = 2'd0;
    #1 chk("R8 saturated value", longint'(rdata1), 255);
    bus_addr = 8'h00;

    // R5 R10: result spanning all three bytes
    measure(3, 10, 5);

    @(negedge clk);
    chk("R5 scoreboard drained", longint'(exp_q.size()), 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule